// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Register Banking

This block decides when a small pipelined controller with delayed branches may be diverted to its interrupt handler. It also steers it back when the handler ends. An interrupt request is latched as pending. It is taken only in a cycle where neither a branch is in fetch nor a delay-slot instruction is executing, so a return address can never point into a delay slot. When it is taken, the block does four things in the same cycle:
- redirects fetch to a fixed vector;
- squashes the instruction that was in fetch;
- writes that instruction's address to the topmost entry of the doubled register file;
- keeps its own copy of that address for the return.

From the next cycle the interrupt-mode bit is set. The block prepends this bit as the most significant bit of every register index. Handler code therefore works in the upper half of the register file with unchanged instruction encodings. Ordinary subroutine calls are not handled here: they write their return address to the register their instruction names.

A return-from-interrupt decode, seen while in interrupt mode, redirects fetch to the saved address and clears the mode bit for the following cycle. All pins are plain level control. The interrupt request is a sticky request rather than a stream, so there is no back-pressure. `irq_ack` marks the single cycle in which a pending request is consumed.

Top module: `irq_bank_seq`

## Requirements
- R1: After reset `int_mode` is 0, `redirect_valid`, `squash`, `irq_ack` and `save_we` are 0, and no request is pending.
- R2: When a request is pending or being raised, `int_mode` is 0, `fetch_is_branch` is 0 and `slot_active` is 0, the block takes it in that same cycle. In that cycle `irq_ack`, `redirect_valid` and `squash` are 1, and `redirect_pc` equals the parameter `VECTOR`.
- R3: In the cycle a request is taken, `save_we` is 1, `save_idx` is all ones (63 with 5-bit architectural indices), and `save_data` equals `fetch_pc`.
- R4: `int_mode` becomes 1 in the cycle after a request is taken. Each extended index field k of `bank_idx` equals `{int_mode, arch_idx field k}`. Field k occupies bits k*IDX_W and upward of `arch_idx`, and bits k*(IDX_W+1) and upward of `bank_idx`.
- R5: No request is taken in a cycle where `fetch_is_branch` is 1.
- R6: No request is taken in a cycle where `slot_active` is 1. A deferred request is taken in the first later cycle where both branch inputs are 0.
- R7: While `int_mode` is 1, requests are not taken but remain pending. A request pending at the end of a handler is taken in the cycle after the return clears the mode.
- R8: An `rti_decode` while `int_mode` is 1 drives `redirect_valid` and `squash` to 1, with `redirect_pc` equal to the address saved at entry. `int_mode` reads 0 from the next cycle.
- R9: An `rti_decode` while `int_mode` is 0 has no effect: no redirect, and `int_mode` stays 0.
- R10: A one-cycle request pulse that cannot be taken at once is remembered until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request; a high cycle sets pending |
| fetch_pc | input | PC_W | Address of the instruction in fetch |
| fetch_is_branch | input | 1 | A branch instruction is in fetch |
| slot_active | input | 1 | A delay-slot instruction is executing |
| rti_decode | input | 1 | Return-from-interrupt decoded |
| arch_idx | input | N_PORTS*IDX_W | Architectural register indices, packed |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | PC_W | Redirect target |
| squash | output | 1 | Kill the instruction in fetch |
| irq_ack | output | 1 | Pending request consumed this cycle |
| int_mode | output | 1 | Interrupt-mode bit |
| save_we | output | 1 | Write return PC into the register file |
| save_idx | output | IDX_W+1 | Extended index for the return PC |
| save_data | output | PC_W | Return PC value |
| bank_idx | output | N_PORTS*(IDX_W+1) | Bank-extended indices, packed |

## Verification
A stuck or lost pending flag shows up as a missing `irq_ack` in the first legal cycle after a branch window closes, or after a return. A lost or wrong saved address shows up in the `redirect_pc` of the very next return. A wrong mode bit shows up in the top bit of every `bank_idx` field one cycle after entry or return, so the bench samples those fields exactly one cycle after each transition.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_IRQ  = 2'd1,
    RD_RTI  = 2'd2
  } redir_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic fetch_is_branch,
  input  logic slot_active,
  input  logic int_mode,
  output logic take
);
  logic pend_q;
  logic want;

  // a request is wanted if it is latched or being raised now
  assign want = pend_q | irq_req;
  // legal only outside branch/delay-slot windows and outside a handler
  assign take = want & ~int_mode & ~fetch_is_branch & ~slot_active;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want & ~take;
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import irq_bank_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            rti_decode,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            int_mode,
  output redir_e          cause,
  output logic [PC_W-1:0] ret_pc
);
  logic mode_q;
  logic rti_go;

  assign rti_go   = rti_decode & mode_q;
  assign int_mode = mode_q;

  always_comb begin
    if (take)        cause = RD_IRQ;
    else if (rti_go) cause = RD_RTI;
    else             cause = RD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ret_pc <= '0;
    end else if (take) begin
      mode_q <= 1'b1;
      ret_pc <= fetch_pc;
    end else if (rti_go) begin
      mode_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_ext.sv
module bank_ext #(
  parameter int IDX_W   = 5,
  parameter int N_PORTS = 3,
  localparam int EXT_W  = IDX_W + 1
) (
  input  logic                     int_mode,
  input  logic [N_PORTS*IDX_W-1:0] arch_idx,
  output logic [N_PORTS*EXT_W-1:0] bank_idx
);
  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    assign bank_idx[k*EXT_W +: EXT_W] = {int_mode, arch_idx[k*IDX_W +: IDX_W]};
  end
endmodule

// File: rtl/irq_bank_seq.sv
module irq_bank_seq
  import irq_bank_pkg::*;
#(
  parameter int              PC_W    = 16,
  parameter int              IDX_W   = 5,
  parameter int              N_PORTS = 3,
  parameter logic [PC_W-1:0] VECTOR  = 16'h0040,
  localparam int             EXT_W   = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     irq_req,
  input  logic [PC_W-1:0]          fetch_pc,
  input  logic                     fetch_is_branch,
  input  logic                     slot_active,
  input  logic                     rti_decode,
  input  logic [N_PORTS*IDX_W-1:0] arch_idx,
  output logic                     redirect_valid,
  output logic [PC_W-1:0]          redirect_pc,
  output logic                     squash,
  output logic                     irq_ack,
  output logic                     int_mode,
  output logic                     save_we,
  output logic [EXT_W-1:0]         save_idx,
  output logic [PC_W-1:0]          save_data,
  output logic [N_PORTS*EXT_W-1:0] bank_idx
);
  logic            take;
  redir_e          cause;
  logic [PC_W-1:0] ret_pc;

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .fetch_is_branch(fetch_is_branch), .slot_active(slot_active),
    .int_mode(int_mode), .take(take)
  );

  mode_ctrl #(.PC_W(PC_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .take(take), .rti_decode(rti_decode),
    .fetch_pc(fetch_pc), .int_mode(int_mode), .cause(cause), .ret_pc(ret_pc)
  );

  bank_ext #(.IDX_W(IDX_W), .N_PORTS(N_PORTS)) u_bank (
    .int_mode(int_mode), .arch_idx(arch_idx), .bank_idx(bank_idx)
  );

  assign redirect_valid = (cause != RD_NONE);
  assign redirect_pc    = (cause == RD_IRQ) ? VECTOR : ret_pc;
  assign squash         = redirect_valid;
  assign irq_ack        = (cause == RD_IRQ);
  assign save_we        = irq_ack;
  assign save_idx       = '1;
  assign save_data      = fetch_pc;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int              PC_W   = 16,
  parameter int              EXT_W  = 6,
  parameter logic [PC_W-1:0] VECTOR = 16'h0040
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_is_branch,
  input logic             slot_active,
  input logic             rti_decode,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             redirect_valid,
  input logic [PC_W-1:0]  redirect_pc,
  input logic             squash,
  input logic             irq_ack,
  input logic             int_mode,
  input logic             save_we,
  input logic [EXT_W-1:0] save_idx,
  input logic [PC_W-1:0]  save_data
);
  // R2
  entry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (redirect_valid && squash && redirect_pc == VECTOR));
  // R3
  save_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (save_we && save_idx == {EXT_W{1'b1}} && save_data == fetch_pc));
  // R4
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> int_mode);
  // R5
  no_take_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_is_branch |-> !irq_ack);
  // R6
  no_take_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_active |-> !irq_ack);
  // R7
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_mode |-> !irq_ack);
  // R8
  rti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_decode && int_mode) |=> !int_mode);
  // R9
  rti_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_decode && !int_mode && !irq_ack) |-> !redirect_valid);
endmodule

bind irq_bank_seq irq_bank_chk #(.PC_W(PC_W), .EXT_W(EXT_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_is_branch(fetch_is_branch),
  .slot_active(slot_active), .rti_decode(rti_decode), .fetch_pc(fetch_pc),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .squash(squash),
  .irq_ack(irq_ack), .int_mode(int_mode), .save_we(save_we),
  .save_idx(save_idx), .save_data(save_data)
);

// File: tb/irq_bank_seq_bench.sv
module irq_bank_seq_bench;
  localparam int PC_W = 16;
  localparam int IDX_W = 5;
  localparam int NP = 3;
  localparam int EXT_W = IDX_W + 1;
  localparam logic [PC_W-1:0] VEC = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic fetch_is_branch = 1'b0;
  logic slot_active = 1'b0;
  logic rti_decode = 1'b0;
  logic [NP*IDX_W-1:0] arch_idx = '0;
  logic redirect_valid, squash, irq_ack, int_mode, save_we;
  logic [PC_W-1:0] redirect_pc, save_data;
  logic [EXT_W-1:0] save_idx;
  logic [NP*EXT_W-1:0] bank_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_bank_seq #(.PC_W(PC_W), .IDX_W(IDX_W), .N_PORTS(NP), .VECTOR(VEC)) u_irq_bank_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fetch_pc(fetch_pc),
    .fetch_is_branch(fetch_is_branch), .slot_active(slot_active),
    .rti_decode(rti_decode), .arch_idx(arch_idx),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .squash(squash),
    .irq_ack(irq_ack), .int_mode(int_mode), .save_we(save_we),
    .save_idx(save_idx), .save_data(save_data), .bank_idx(bank_idx)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, outputs settle one time unit later
  task automatic drive(logic req, logic br, logic slot, logic rti, logic [PC_W-1:0] pc);
    @(negedge clk);
    irq_req = req; fetch_is_branch = br; slot_active = slot;
    rti_decode = rti; fetch_pc = pc;
    #1;
  endtask

  task automatic t_reset;
    check("R1 int_mode", int_mode, 0);
    check("R1 redirect", redirect_valid, 0);
    check("R1 ack", irq_ack, 0);
    check("R1 save_we", save_we, 0);
    drive(0, 0, 0, 0, 16'h0010);
    check("R1 no pending", irq_ack, 0);
  endtask

  task automatic t_basic_entry;
    drive(1, 0, 0, 0, 16'h0100);
    check("R2 ack", irq_ack, 1);
    check("R2 redirect", redirect_valid, 1);
    check("R2 squash", squash, 1);
    check("R2 vector", redirect_pc, VEC);
    check("R3 save_we", save_we, 1);
    check("R3 save_idx", save_idx, 6'd63);
    check("R3 save_data", save_data, 16'h0100);
    check("R4 mode not yet", int_mode, 0);
    drive(0, 0, 0, 0, 16'h0040);
    arch_idx = {5'd7, 5'd0, 5'd31};
    #1;
    check("R4 mode set", int_mode, 1);
    check("R4 idx0", bank_idx[0 +: EXT_W], {1'b1, 5'd31});
    check("R4 idx1", bank_idx[EXT_W +: EXT_W], {1'b1, 5'd0});
    check("R4 idx2", bank_idx[2*EXT_W +: EXT_W], {1'b1, 5'd7});
  endtask

  task automatic t_rti;
    drive(0, 0, 0, 1, 16'h0044);
    check("R8 redirect", redirect_valid, 1);
    check("R8 squash", squash, 1);
    check("R8 target", redirect_pc, 16'h0100);
    drive(0, 0, 0, 0, 16'h0100);
    check("R8 mode clear", int_mode, 0);
    check("R4 idx normal", bank_idx[0 +: EXT_W], {1'b0, 5'd31});
  endtask

  task automatic t_rti_ignored;
    drive(0, 0, 0, 1, 16'h0104);
    check("R9 no redirect", redirect_valid, 0);
    drive(0, 0, 0, 0, 16'h0108);
    check("R9 mode stays", int_mode, 0);
  endtask

  task automatic t_branch_defer;
    drive(1, 1, 0, 0, 16'h0200);
    check("R5 no take on branch", irq_ack, 0);
    drive(0, 0, 1, 0, 16'h0204);
    check("R6 no take in slot", irq_ack, 0);
    drive(0, 0, 0, 0, 16'h0208);
    check("R10 pending taken", irq_ack, 1);
    check("R6 save after slot", save_data, 16'h0208);
    drive(0, 0, 0, 0, 16'h0040);
    check("R4 mode set", int_mode, 1);
  endtask

  task automatic t_no_nest;
    drive(1, 0, 0, 0, 16'h0044);
    check("R7 no nested take", irq_ack, 0);
    drive(0, 0, 0, 0, 16'h0048);
    check("R7 still none", irq_ack, 0);
    drive(0, 0, 0, 1, 16'h004c);
    check("R7 rti target", redirect_pc, 16'h0208);
    drive(0, 0, 0, 0, 16'h0208);
    check("R7 pending taken after rti", irq_ack, 1);
    check("R7 save", save_data, 16'h0208);
    drive(0, 0, 0, 0, 16'h0040);
    drive(0, 0, 0, 1, 16'h0044);
    drive(0, 0, 0, 0, 16'h0208);
    check("R8 mode clear again", int_mode, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_basic_entry();
    t_rti();
    t_rti_ignored();
    t_branch_defer();
    t_no_nest();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule